// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This block is a memory-mapped peripheral that moves 32-bit words between a local buffer of 512 words and an on-chip configuration port, in either direction. A host bus reaches every buffer word and four control and status registers. Software loads the buffer, sets a byte length and a starting word index, and then writes a direction value. That write launches the transfer.

In configure mode the engine reads the buffer from the start index upward and offers each word to the port on a valid/ready handshake. In readback mode it stores every word the port marks valid into the buffer at successive indices. When the last word has moved, a done flag in the status word rises again, and the host polls that flag. A write to the status register cancels whatever is running. The status word also carries four port condition inputs, each passed through one register stage.

Top module: `cfgport_xfer`

## Requirements
- R1: The bus address is a word address (`bus_addr` = byte address / 4). Word addresses 0 to 511 select buffer words. A read returns its data on `bus_rdata` with `bus_rvalid` high, one cycle after the request.
- R2: Word address 0x200 (byte 0x800) is the length register, 32 bits, read/write. Word address 0x201 (byte 0x804) is the start index, and only its low 9 bits are stored. Word address 0x202 (byte 0x808) reads as 0.
- R3: Any write to word address 0x202 while idle starts a transfer of length>>2 words. Write data bit 0 = 1 selects readback and 0 selects configure. Status bit 0 reads 0 while the transfer runs.
- R4: A start with a length below 4 bytes moves nothing. Status bit 0 stays 1, `cp_out_valid` stays low and `cp_rd_req` stays low.
- R5: In configure mode, buffer words leave in ascending index order from the start index. Each word is held on `cp_out_data` with `cp_out_valid` high until `cp_out_ready` is seen. After the last word is accepted, `cp_out_valid` drops and status bit 0 reads 1.
- R6: In readback mode, `cp_rd_req` is high while the transfer runs. Each cycle with `cp_in_valid` high stores `cp_in_data` at the next index. After the last word `cp_rd_req` drops and the transfer ends.
- R7: The buffer index wraps from 511 to 0 when the start index plus the word count runs past the end.
- R8: The status word (word address 0x203) has done in bit 0, ones in bits 1 to 4, and `cp_abort_n`, `cp_rip`, `cp_aligned` and `cp_err` in bits 5, 6, 7 and 8. All other bits are 0.
- R9: The status bits 5 to 8 lag the port inputs by one register stage.
- R10: Any write to word address 0x203 aborts a running transfer. On the next cycle `cp_out_valid` and `cp_rd_req` are low and status bit 0 is 1.
- R11: While a transfer runs, writes to the length, start-index and direction registers have no effect.
- R12: If a bus write and a readback capture hit the same buffer word in the same cycle, the captured port word is the one stored.
- R13: After reset, the length and the start index are 0, status bit 0 is 1, and `cp_out_valid` and `cp_rd_req` are low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cp_out_data | output | 32 | Word offered to the configuration port |
| cp_out_valid | output | 1 | cp_out_data holds a word to deliver |
| cp_out_ready | input | 1 | Port accepts the offered word |
| cp_rd_req | output | 1 | Readback transfer running; port may send words |
| cp_in_data | input | 32 | Word from the configuration port |
| cp_in_valid | input | 1 | cp_in_data holds a word to capture |
| cp_abort_n | input | 1 | Port abort status, active low |
| cp_rip | input | 1 | Port readback-in-progress status |
| cp_aligned | input | 1 | Port data-aligned status |
| cp_err | input | 1 | Port configuration error status |

## Verification
Two events can meet in the same clock cycle: a host store into the buffer and a readback capture from the port. The bench provokes this by raising `cp_in_valid` on the very edge where a bus write targets the word the engine is about to fill. It then reads that word back through the bus and expects the port's value. A second case of this kind is a status write that lands while a configure word is stalled: the abort must win over the pending handshake, and the offered word must vanish on the next cycle.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    // register selector: low two bits of the word address in the register window
    localparam logic [1:0] RSEL_LEN  = 2'd0;
    localparam logic [1:0] RSEL_BASE = 2'd1;
    localparam logic [1:0] RSEL_DIR  = 2'd2;
    localparam logic [1:0] RSEL_STAT = 2'd3;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_CONF = 2'd1,
        XS_READ = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/cfgport_buf.sv
module cfgport_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              e_we,
    input  logic [IDX_W-1:0]  e_widx,
    input  logic [DATA_W-1:0] e_wdata,
    input  logic [IDX_W-1:0]  e_ridx,
    output logic [DATA_W-1:0] e_rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] h_rdata_q;

    // the engine store comes last, so on an index clash it is the one kept
    always_ff @(posedge clk) begin
        if (h_we) begin
            mem_q[h_idx] <= h_wdata;
        end
        if (e_we) begin
            mem_q[e_widx] <= e_wdata;
        end
        if (h_re) begin
            h_rdata_q <= mem_q[h_idx];
        end
    end

    assign h_rdata = h_rdata_q;
    assign e_rdata = mem_q[e_ridx];

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9,
    parameter int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              buf_we,
    output logic              buf_re,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic              done,
    input  logic              cp_abort_n,
    input  logic              cp_rip,
    input  logic              cp_aligned,
    input  logic              cp_err,
    output logic              start,
    output logic              start_rb,
    output logic              abort,
    output logic [DATA_W-1:0] size_q,
    output logic [IDX_W-1:0]  base_q
);

    typedef struct packed {
        logic [DATA_W-1:0] size;
        logic [IDX_W-1:0]  base;
        logic [3:0]        port_st;   // {err, aligned, rip, abort_n}
        logic              sel_buf;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic              in_buf;
    logic              in_regs;
    logic [1:0]        rsel;
    logic              wr;
    logic              rd;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        in_buf  = ~bus_addr[ADDR_W-1];
        in_regs = bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:2] == '0);
        rsel    = bus_addr[1:0];
        wr      = bus_req && bus_we;
        rd      = bus_req && !bus_we;

        status_word      = '0;
        status_word[0]   = done;
        status_word[4:1] = 4'b1111;
        status_word[8:5] = r_q.port_st;

        r_d         = r_q;
        r_d.port_st = {cp_err, cp_aligned, cp_rip, cp_abort_n};
        r_d.rvalid  = rd;

        if (rd) begin
            r_d.sel_buf = in_buf;
            r_d.rdata   = '0;
            if (in_regs) begin
                case (rsel)
                    RSEL_LEN:  r_d.rdata = r_q.size;
                    RSEL_BASE: r_d.rdata = DATA_W'(r_q.base);
                    RSEL_DIR:  r_d.rdata = '0;
                    default:   r_d.rdata = status_word;
                endcase
            end
        end

        if (wr && in_regs && done) begin
            if (rsel == RSEL_LEN) begin
                r_d.size = bus_wdata;
            end
            if (rsel == RSEL_BASE) begin
                r_d.base = bus_wdata[IDX_W-1:0];
            end
        end

        start    = wr && in_regs && (rsel == RSEL_DIR) && done;
        start_rb = bus_wdata[0];
        abort    = wr && in_regs && (rsel == RSEL_STAT);
        buf_we   = wr && in_buf;
        buf_re   = rd && in_buf;
        buf_idx  = bus_addr[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.port_st <= 4'b0001;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata  = r_q.sel_buf ? buf_rdata : r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign size_q     = r_q.size;
    assign base_q     = r_q.base;

endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
    import cfgport_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9,
    parameter int CNT_W  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rb,
    input  logic              abort,
    input  logic [CNT_W-1:0]  n_words,
    input  logic [IDX_W-1:0]  base,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              rd_req,
    output logic              done
);

    typedef struct packed {
        xfer_state_e       state;
        logic [IDX_W-1:0]  ptr;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] odata;
        logic              ovalid;
        logic              done;
    } eng_t;

    eng_t e_q, e_d;

    logic [IDX_W-1:0] ptr_nx;

    always_comb begin
        ptr_nx = e_q.ptr + IDX_W'(1);
        // idle: look at the start index; configuring: look one word ahead
        rd_idx = (e_q.state == XS_IDLE) ? base : ptr_nx;

        e_d = e_q;
        case (e_q.state)
            XS_IDLE: begin
                if (start && (n_words != '0)) begin
                    e_d.ptr  = base;
                    e_d.left = n_words;
                    e_d.done = 1'b0;
                    if (start_rb) begin
                        e_d.state = XS_READ;
                    end else begin
                        e_d.state  = XS_CONF;
                        e_d.odata  = rd_word;
                        e_d.ovalid = 1'b1;
                    end
                end
            end
            XS_CONF: begin
                if (e_q.ovalid && out_ready) begin
                    if (e_q.left == CNT_W'(1)) begin
                        e_d.state  = XS_IDLE;
                        e_d.ovalid = 1'b0;
                        e_d.done   = 1'b1;
                    end else begin
                        e_d.left  = e_q.left - CNT_W'(1);
                        e_d.ptr   = ptr_nx;
                        e_d.odata = rd_word;
                    end
                end
            end
            XS_READ: begin
                if (in_valid) begin
                    if (e_q.left == CNT_W'(1)) begin
                        e_d.state = XS_IDLE;
                        e_d.done  = 1'b1;
                    end else begin
                        e_d.left = e_q.left - CNT_W'(1);
                        e_d.ptr  = ptr_nx;
                    end
                end
            end
            default: begin
                e_d.state = XS_IDLE;
                e_d.done  = 1'b1;
            end
        endcase

        if (abort) begin
            e_d.state  = XS_IDLE;
            e_d.ovalid = 1'b0;
            e_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= XS_IDLE;
            e_q.done  <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign wr_en     = (e_q.state == XS_READ) && in_valid;
    assign wr_idx    = e_q.ptr;
    assign wr_word   = in_data;
    assign out_data  = e_q.odata;
    assign out_valid = e_q.ovalid;
    assign rd_req    = (e_q.state == XS_READ);
    assign done      = e_q.done;

endmodule

// File: rtl/cfgport_xfer.sv
module cfgport_xfer #(
    parameter int DATA_W    = 32,
    parameter int BUF_WORDS = 512,
    parameter int ADDR_W    = $clog2(BUF_WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] cp_out_data,
    output logic              cp_out_valid,
    input  logic              cp_out_ready,
    output logic              cp_rd_req,
    input  logic [DATA_W-1:0] cp_in_data,
    input  logic              cp_in_valid,
    input  logic              cp_abort_n,
    input  logic              cp_rip,
    input  logic              cp_aligned,
    input  logic              cp_err
);

    localparam int IDX_W = ADDR_W - 1;
    localparam int CNT_W = DATA_W - 2;

    logic              h_we, h_re;
    logic [IDX_W-1:0]  h_idx;
    logic [DATA_W-1:0] h_rdata;
    logic              e_we;
    logic [IDX_W-1:0]  e_widx, e_ridx;
    logic [DATA_W-1:0] e_wdata, e_rdata;
    logic              start, start_rb, abort, done, busy;
    logic [DATA_W-1:0] size_q;
    logic [IDX_W-1:0]  base_q;

    assign busy = ~done;

    cfgport_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (BUF_WORDS),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk     (clk),
        .h_we    (h_we),
        .h_re    (h_re),
        .h_idx   (h_idx),
        .h_wdata (bus_wdata),
        .h_rdata (h_rdata),
        .e_we    (e_we),
        .e_widx  (e_widx),
        .e_wdata (e_wdata),
        .e_ridx  (e_ridx),
        .e_rdata (e_rdata)
    );

    cfgport_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .buf_rdata  (h_rdata),
        .buf_we     (h_we),
        .buf_re     (h_re),
        .buf_idx    (h_idx),
        .done       (done),
        .cp_abort_n (cp_abort_n),
        .cp_rip     (cp_rip),
        .cp_aligned (cp_aligned),
        .cp_err     (cp_err),
        .start      (start),
        .start_rb   (start_rb),
        .abort      (abort),
        .size_q     (size_q),
        .base_q     (base_q)
    );

    cfgport_engine #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rb  (start_rb),
        .abort     (abort),
        .n_words   (size_q[DATA_W-1:2]),
        .base      (base_q),
        .rd_idx    (e_ridx),
        .rd_word   (e_rdata),
        .wr_en     (e_we),
        .wr_idx    (e_widx),
        .wr_word   (e_wdata),
        .out_data  (cp_out_data),
        .out_valid (cp_out_valid),
        .out_ready (cp_out_ready),
        .in_data   (cp_in_data),
        .in_valid  (cp_in_valid),
        .rd_req    (cp_rd_req),
        .done      (done)
    );

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] cp_out_data,
    input logic              cp_out_valid,
    input logic              cp_out_ready,
    input logic              cp_rd_req,
    input logic              busy,
    input logic [DATA_W-1:0] size_q
);

    localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(1 << (ADDR_W - 1));
    localparam logic [ADDR_W-1:0] A_DIR  = A_LEN + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_STAT = A_LEN + ADDR_W'(3);

    logic wr_len, wr_dir, wr_stat, len_small;
    assign wr_len    = bus_req && bus_we && (bus_addr == A_LEN);
    assign wr_dir    = bus_req && bus_we && (bus_addr == A_DIR);
    assign wr_stat   = bus_req && bus_we && (bus_addr == A_STAT);
    assign len_small = (size_q[DATA_W-1:2] == '0);

    // R5
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_out_valid && !cp_out_ready && !wr_stat) |=> (cp_out_valid && $stable(cp_out_data)));

    // R10
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (!cp_out_valid && !cp_rd_req && !busy));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_dir && !len_small) |=> busy);

    // R4
    tiny_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_dir && len_small) |=> (!busy && !cp_out_valid && !cp_rd_req));

    // R11
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_len) |=> $stable(size_q));

    // R6
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_rd_req |-> !cp_out_valid);

endmodule

bind cfgport_xfer cfgport_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .cp_out_data  (cp_out_data),
    .cp_out_valid (cp_out_valid),
    .cp_out_ready (cp_out_ready),
    .cp_rd_req    (cp_rd_req),
    .busy         (busy),
    .size_q       (size_q)
);

// File: tb/test_cfgport_xfer.sv
module test_cfgport_xfer;

    localparam logic [9:0] A_LEN  = 10'h200;
    localparam logic [9:0] A_BASE = 10'h201;
    localparam logic [9:0] A_DIR  = 10'h202;
    localparam logic [9:0] A_STAT = 10'h203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] cp_out_data;
    logic        cp_out_valid;
    logic        cp_out_ready = 1'b0;
    logic        cp_rd_req;
    logic [31:0] cp_in_data = '0;
    logic        cp_in_valid = 1'b0;
    logic        cp_abort_n = 1'b1, cp_rip = 1'b0, cp_aligned = 1'b0, cp_err = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfgport_xfer i_cfgport_xfer (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cp_out_data(cp_out_data), .cp_out_valid(cp_out_valid),
        .cp_out_ready(cp_out_ready), .cp_rd_req(cp_rd_req),
        .cp_in_data(cp_in_data), .cp_in_valid(cp_in_valid),
        .cp_abort_n(cp_abort_n), .cp_rip(cp_rip),
        .cp_aligned(cp_aligned), .cp_err(cp_err)
    );

    typedef struct packed {
        logic [8:0]  base;
        logic [31:0] len;
        logic        stall;
    } vec_t;

    // configure transfers: start index, byte length, ready throttling
    localparam vec_t VECS [6] = '{
        '{9'd0,   32'd16, 1'b0},
        '{9'd5,   32'd12, 1'b1},
        '{9'd510, 32'd16, 1'b1},
        '{9'd100, 32'd7,  1'b0},
        '{9'd3,   32'd2,  1'b0},
        '{9'd200, 32'd4,  1'b1}
    };

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        check("R1 rvalid", 32'(bus_rvalid), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 out_valid", 32'(cp_out_valid), 32'd0);
        check("R13 rd_req", 32'(cp_rd_req), 32'd0);
        bus_rd(A_LEN, rv);  check("R13 length", rv, 32'd0);
        bus_rd(A_BASE, rv); check("R13 base", rv, 32'd0);
        bus_rd(A_STAT, rv); check("R13 R8 status", rv, 32'h0000_003F);
        bus_rd(A_DIR, rv);  check("R2 dir reads 0", rv, 32'd0);

        // R2 register width
        bus_wr(A_LEN, 32'h1234_5677);
        bus_rd(A_LEN, rv);  check("R2 length", rv, 32'h1234_5677);
        bus_wr(A_BASE, 32'hFFFF_FE05);
        bus_rd(A_BASE, rv); check("R2 base 9 bits", rv, 32'h0000_0005);

        // R1 fill and spot-check the buffer
        for (int i = 0; i < 512; i++) bus_wr(10'(i), pat(i));
        bus_rd(10'd0, rv);   check("R1 word 0", rv, pat(0));
        bus_rd(10'd511, rv); check("R1 word 511", rv, pat(511));

        // R5 / R7 / R4 configure vectors
        foreach (VECS[v]) begin
            int k;
            int nw;
            string tag;
            nw  = int'(VECS[v].len >> 2);
            tag = (int'(VECS[v].base) + nw > 512) ? "R7" : ((nw == 0) ? "R4" : "R5");
            k = 0;
            bus_wr(A_LEN, VECS[v].len);
            bus_wr(A_BASE, 32'(VECS[v].base));
            bus_wr(A_DIR, 32'd0);
            for (int g = 0; g < 400 && cp_out_valid; g++) begin
                cp_out_ready = VECS[v].stall ? g[0] : 1'b1;
                if (cp_out_valid && cp_out_ready) begin
                    check(tag, cp_out_data, pat((int'(VECS[v].base) + k) % 512));
                    k++;
                end
                @(negedge clk);
            end
            cp_out_ready = 1'b0;
            check({tag, " word count"}, 32'(k), 32'(nw));
            bus_rd(A_STAT, rv); check({tag, " done"}, 32'(rv[0]), 32'd1);
        end

        // R11 / R3 / R10 busy-time writes, then abort of a stalled word
        bus_wr(A_LEN, 32'd8);
        bus_wr(A_BASE, 32'd40);
        bus_wr(A_DIR, 32'd0);
        bus_rd(A_STAT, rv); check("R3 done low while busy", 32'(rv[0]), 32'd0);
        bus_wr(A_LEN, 32'd100);
        bus_wr(A_BASE, 32'd7);
        bus_wr(A_DIR, 32'd1);
        bus_rd(A_LEN, rv);  check("R11 length kept", rv, 32'd8);
        bus_rd(A_BASE, rv); check("R11 base kept", rv, 32'd40);
        check("R11 dir ignored", 32'(cp_rd_req), 32'd0);
        check("R5 stalled word", cp_out_data, pat(40));
        check("R5 stalled valid", 32'(cp_out_valid), 32'd1);
        bus_wr(A_STAT, 32'h0000_FEFE);
        check("R10 valid dropped", 32'(cp_out_valid), 32'd0);
        bus_rd(A_STAT, rv); check("R10 done", 32'(rv[0]), 32'd1);

        // R6 / R7 readback with wrap and gaps
        bus_wr(A_LEN, 32'd12);
        bus_wr(A_BASE, 32'd511);
        bus_wr(A_DIR, 32'd1);
        check("R6 rd_req high", 32'(cp_rd_req), 32'd1);
        for (int w = 0; w < 3; w++) begin
            cp_in_valid = 1'b1; cp_in_data = 32'hBEEF_0000 + 32'(w);
            @(negedge clk);
            cp_in_valid = 1'b0;
            if (w < 2) begin
                check("R6 rd_req mid", 32'(cp_rd_req), 32'd1);
                @(negedge clk);
            end
        end
        check("R6 rd_req low at end", 32'(cp_rd_req), 32'd0);
        bus_rd(10'd511, rv); check("R6 word 511", rv, 32'hBEEF_0000);
        bus_rd(10'd0, rv);   check("R7 wrapped word 0", rv, 32'hBEEF_0001);
        bus_rd(10'd1, rv);   check("R7 wrapped word 1", rv, 32'hBEEF_0002);
        bus_rd(10'd2, rv);   check("R6 word 2 untouched", rv, pat(2));

        // R12 capture and host store on the same word, same edge
        bus_wr(A_LEN, 32'd4);
        bus_wr(A_BASE, 32'd20);
        bus_wr(A_DIR, 32'd1);
        cp_in_valid = 1'b1; cp_in_data = 32'hC0FF_EE00;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'd20; bus_wdata = 32'hDEAD_0001;
        @(negedge clk);
        cp_in_valid = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        bus_rd(10'd20, rv); check("R12 capture wins", rv, 32'hC0FF_EE00);

        // R8 / R9 port status bits and their register lag
        cp_abort_n = 1'b0; cp_rip = 1'b1; cp_aligned = 1'b1; cp_err = 1'b0;
        bus_rd(A_STAT, rv); check("R9 old status", rv, 32'h0000_003F);
        bus_rd(A_STAT, rv); check("R8 new status", rv, 32'h0000_00DF);
        cp_abort_n = 1'b1; cp_rip = 1'b0; cp_aligned = 1'b0; cp_err = 1'b1;
        @(negedge clk);
        bus_rd(A_STAT, rv); check("R8 err bit", rv, 32'h0000_013F);

        finish_run();
    end

endmodule